// File: doc/BRIEF.md
# DMA Controller Register Slave with Interrupt Assembly

This block is the register side of a multi-channel DMA engine. Software reaches it with 32-bit word accesses. A request is a valid/ready transfer. A response is returned one cycle later as a valid/ready transfer that can be held back. The offset space has two parts. A small global window below the channel base holds a control word, two interrupt mask words (A and B) and two interrupt source words (A and B). Above the base, the same block of channel registers repeats once per channel at a fixed stride.

The data-moving side of the engine drives one event pulse line per channel. When a channel reports an event and its bit in mask A is set, source A takes that channel's one-hot code. The single interrupt output stays high while source A and mask A share any set bit. Accesses that are misaligned or fall on no register return an error flag with zero data and change nothing.

Back-pressure works as follows. The block takes a request when `req_valid` and `req_ready` are both high at a clock edge. It answers in the next cycle with `rsp_valid`. The response data and error flag stay frozen until the master accepts them with `rsp_ready`. While a response is waiting, `req_ready` is low.

Top module: `dma_regbank`

## Requirements
- R1: An access whose offset has bits [1:0] nonzero is misaligned. It gets `rsp_err`=1 and `rsp_rdata`=0, and a write to it changes no register.
- R2: Offsets below 0x20 address the global words: 0x00 control, 0x04 mask A, 0x08 mask B, 0x0C source A, 0x10 source B.
- R3: For an offset at or above 0x20, the channel is (offset-0x20)/0x20 and the word is (offset-0x20)%0x20. Per-channel words are: +0x00 control/status, +0x04 size, +0x08 source address, +0x0C source mask, +0x10 destination address, +0x14 destination mask.
- R4: After reset, both mask words of every channel read 0xFFFFFFFC and every other register reads 0.
- R5: The global offsets 0x14–0x1C, the channel offsets +0x18 and +0x1C, and offsets at or above 0xA0 are unmapped. They get `rsp_err`=1 and `rsp_rdata`=0, and writes to them change nothing.
- R6: Mask A, mask B, source A, source B and all channel words store the full written value and read it back. A write response carries zero data and `rsp_err`=0.
- R7: If `ch_evt` has bits set whose mask A bits are also set, source A is loaded at that edge with the one-hot code of the lowest such channel. This overrides a bus write to source A in the same cycle. Events on channels whose mask A bit is clear do not change source A.
- R8: `irq_o` is high exactly when (source A AND mask A) is nonzero. Writing source A to zero drops it one cycle after the write is accepted.
- R9: The global control word always reads 0. Writing it, including with bit 0 (pause) set, has no effect.
- R10: A request accepted at an edge gives `rsp_valid`=1 after that edge. While `rsp_valid`=1 and `rsp_ready`=0, the response stays stable and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Misaligned or unmapped access |
| ch_evt | input | 4 | Per-channel interrupt event pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every response becomes visible one edge after the request is accepted. A register write is visible in a read issued any time after it. The bench drives each request at a falling edge and samples the response at the next falling edge, which puts exactly one rising edge between them. An event sets source A at the rising edge where it is sampled. `irq_o` follows from registered state, so the bench pulses `ch_evt` for one cycle and checks `irq_o` and the read-back of source A at the following falling edge. The held-response case keeps `rsp_ready` low across two falling edges and compares the frozen data against the first sample.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int GLB_WORDS = 5;
  localparam int CH_WORDS  = 6;

  typedef enum logic [2:0] {
    G_CTRL = 3'd0, G_MSKA = 3'd1, G_MSKB = 3'd2, G_SRCA = 3'd3, G_SRCB = 3'd4
  } glb_reg_e;

  typedef struct packed {
    logic       err;
    logic       glob;
    logic       chan;
    logic [2:0] word;
  } dec_t;
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
  import dma_rb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int CH_BASE   = 32,
  parameter int CH_STRIDE = 32,
  parameter int CH_IDX_W  = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  output dec_t                dec,
  output logic [CH_IDX_W-1:0] ch_idx
);
  logic [ADDR_W-1:0] rel, idx_full, off;

  always_comb begin
    rel      = addr - ADDR_W'(CH_BASE);
    idx_full = rel / ADDR_W'(CH_STRIDE);
    off      = rel % ADDR_W'(CH_STRIDE);
    dec      = '0;
    ch_idx   = '0;
    if (addr[1:0] != 2'b00) begin
      dec.err = 1'b1;
    end else if (addr < ADDR_W'(CH_BASE)) begin
      if ((addr >> 2) < ADDR_W'(GLB_WORDS)) begin
        dec.glob = 1'b1;
        dec.word = 3'(addr >> 2);
      end else begin
        dec.err = 1'b1;
      end
    end else if (idx_full < ADDR_W'(NUM_CH) && (off >> 2) < ADDR_W'(CH_WORDS)) begin
      dec.chan = 1'b1;
      dec.word = 3'(off >> 2);
      ch_idx   = CH_IDX_W'(idx_full);
    end else begin
      dec.err = 1'b1;
    end
  end
endmodule

// File: rtl/dma_rb_chregs.sv
module dma_rb_chregs
  import dma_rb_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CH_IDX_W-1:0] ch_idx,
  input  logic [2:0]          word,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata
);
  localparam logic [31:0] MASK_RST = 32'hFFFF_FFFC;

  logic [CH_WORDS-1:0][31:0] q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < CH_WORDS; r++) begin : g_word
      localparam logic [31:0] RV = (r == 3 || r == 5) ? MASK_RST : 32'h0;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q[c][r] <= RV;
        else if (wr_en && ch_idx == CH_IDX_W'(c) && word == 3'(r))
          q[c][r] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int r = 0; r < CH_WORDS; r++)
        if (ch_idx == CH_IDX_W'(c) && word == 3'(r)) rdata = q[c][r];
  end
endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq
  import dma_rb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        word,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] evt,
  output logic [31:0]       msk_a,
  output logic [31:0]       msk_b,
  output logic [31:0]       src_a,
  output logic [31:0]       src_b,
  output logic              irq_o
);
  logic [NUM_CH-1:0] hit, pick;

  always_comb begin
    hit  = evt & msk_a[NUM_CH-1:0];
    pick = hit & (~hit + NUM_CH'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk_a <= '0;
      msk_b <= '0;
      src_a <= '0;
      src_b <= '0;
    end else begin
      if (wr_en && word == G_MSKA) msk_a <= wdata;
      if (wr_en && word == G_MSKB) msk_b <= wdata;
      if (wr_en && word == G_SRCB) src_b <= wdata;
      if (|hit)                         src_a <= 32'(pick);
      else if (wr_en && word == G_SRCA) src_a <= wdata;
    end
  end

  assign irq_o = |(src_a & msk_a);

  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> $onehot(src_a)); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == G_SRCA && wdata == 32'h0 && !(|hit)) |=> !irq_o); // R8
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int CH_BASE   = 32,
  parameter int CH_STRIDE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [NUM_CH-1:0] ch_evt,
  output logic              irq_o
);
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  dec_t                dec;
  logic [CH_IDX_W-1:0] ch_idx;
  logic                acc, wr_ok;
  logic [31:0]         ch_rdata, msk_a, msk_b, src_a, src_b, rd_mux;

  dma_rb_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE),
    .CH_STRIDE(CH_STRIDE), .CH_IDX_W(CH_IDX_W)
  ) u_dec (.addr(req_addr), .dec(dec), .ch_idx(ch_idx));

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_ok     = acc && req_we && !dec.err;

  dma_rb_chregs #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_ch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && dec.chan), .ch_idx(ch_idx),
    .word(dec.word), .wdata(req_wdata), .rdata(ch_rdata)
  );

  dma_rb_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && dec.glob), .word(dec.word),
    .wdata(req_wdata), .evt(ch_evt), .msk_a(msk_a), .msk_b(msk_b),
    .src_a(src_a), .src_b(src_b), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.chan) rd_mux = ch_rdata;
    else if (dec.glob) begin
      case (dec.word)
        G_MSKA:  rd_mux = msk_a;
        G_MSKB:  rd_mux = msk_b;
        G_SRCA:  rd_mux = src_a;
        G_SRCB:  rd_mux = src_b;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= dec.err;
      rsp_rdata <= (req_we || dec.err) ? 32'h0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0)); // R1
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10
endmodule

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  ch_evt = '0;
  logic        req_ready, rsp_valid, rsp_err, irq_o;
  logic [31:0] rsp_rdata;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_mska, m_mskb, m_srca, m_srcb;
  logic [31:0] m_ch [4][6];

  always #2.5 clk = ~clk;

  dma_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ch_evt(ch_evt), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mska = 0; m_mskb = 0; m_srca = 0; m_srcb = 0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 6; r++) m_ch[c][r] = (r == 3 || r == 5) ? 32'hFFFF_FFFC : 32'h0;
  endtask

  // expected response of one access, updating the model for writes
  task automatic model(input bit we, input logic [7:0] a, input logic [31:0] d,
                       output bit err, output logic [31:0] rd);
    int c, r;
    err = 1'b0; rd = 32'h0;
    if (a[1:0] != 0) err = 1'b1;
    else if (a < 8'h20) begin
      r = int'(a) / 4;
      if (r >= 5) err = 1'b1;
      else if (we) begin
        if (r == 1) m_mska = d;
        if (r == 2) m_mskb = d;
        if (r == 3) m_srca = d;
        if (r == 4) m_srcb = d;
      end else begin
        rd = (r == 1) ? m_mska : (r == 2) ? m_mskb : (r == 3) ? m_srca : (r == 4) ? m_srcb : 32'h0;
      end
    end else begin
      c = (int'(a) - 32) / 32;
      r = ((int'(a) - 32) % 32) / 4;
      if (c >= 4 || r >= 6) err = 1'b1;
      else if (we) m_ch[c][r] = d;
      else rd = m_ch[c][r];
    end
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [31:0] d,
                        output bit err, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    err = rsp_err; rd = rsp_rdata;
  endtask

  task automatic do_chk(input string req, input bit we, input logic [7:0] a, input logic [31:0] d);
    bit e_err, a_err;
    logic [31:0] e_rd, a_rd;
    model(we, a, d, e_err, e_rd);
    access(we, a, d, a_err, a_rd);
    check({req, " err"}, {31'b0, a_err}, {31'b0, e_err});
    check({req, " data"}, a_rd, e_rd);
  endtask

  initial begin
    bit e; logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R8 reset irq", {31'b0, irq_o}, 32'h0);
    // R4 reset values
    for (int c = 0; c < 4; c++) begin
      do_chk("R4 ch srcmask", 0, 8'(32 + 32*c + 12), 0);
      do_chk("R4 ch dstmask", 0, 8'(32 + 32*c + 20), 0);
      do_chk("R4 ch size", 0, 8'(32 + 32*c + 4), 0);
    end
    // R9 control ignores pause
    do_chk("R9 ctrl write", 1, 8'h00, 32'h0000_0001);
    do_chk("R9 ctrl read", 0, 8'h00, 0);
    // R1 misaligned write then read back target
    do_chk("R1 misaligned wr", 1, 8'h05, 32'hDEAD_BEEF);
    do_chk("R1 check mskA", 0, 8'h04, 0);
    do_chk("R1 misaligned rd", 0, 8'h2A, 0);
    // R5 holes
    do_chk("R5 glob hole", 1, 8'h14, 32'h1234_5678);
    do_chk("R5 ch hole", 1, 8'h38, 32'h1);
    do_chk("R5 past end", 1, 8'hA0, 32'h1);
    do_chk("R5 past end rd", 0, 8'hBC, 0);
    // R3 last channel last word
    do_chk("R3 ch3 dstmask wr", 1, 8'h94, 32'hCAFE_0004);
    do_chk("R3 ch3 dstmask rd", 0, 8'h94, 0);
    do_chk("R3 ch2 srcaddr wr", 1, 8'h68, 32'h0BAD_F00D);
    do_chk("R3 ch2 srcaddr rd", 0, 8'h68, 0);
    // R2/R6 global regs
    do_chk("R2 mskB wr", 1, 8'h08, 32'hA5A5_0F0F);
    do_chk("R2 mskB rd", 0, 8'h08, 0);
    do_chk("R6 srcB wr", 1, 8'h10, 32'h1357_9BDF);
    do_chk("R6 srcB rd", 0, 8'h10, 0);
    // R7 / R8 events
    do_chk("R7 mskA set", 1, 8'h04, 32'h0000_000A);
    @(negedge clk); ch_evt = 4'b0110;
    @(negedge clk); ch_evt = 4'b0000;
    m_srca = 32'h2;
    check("R8 irq after event", {31'b0, irq_o}, 32'h1);
    do_chk("R7 srcA lowest", 0, 8'h0C, 0);
    do_chk("R8 clear srcA", 1, 8'h0C, 0);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    @(negedge clk); ch_evt = 4'b0101;
    @(negedge clk); ch_evt = 4'b0000;
    check("R7 masked event irq", {31'b0, irq_o}, 32'h0);
    do_chk("R7 masked event srcA", 0, 8'h0C, 0);
    // R7 event beats simultaneous write
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 8'h0C; req_wdata = 32'hFFFF_0000; ch_evt = 4'b1000;
    @(negedge clk);
    req_valid = 0; ch_evt = 0; m_srca = 32'h8;
    check("R7 evt over write", {31'b0, irq_o}, 32'h1);
    do_chk("R7 evt over write srcA", 0, 8'h0C, 0);
    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_we = 0; req_addr = 8'h08;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    check("R10 ready low", {31'b0, req_ready}, 32'h0);
    check("R10 data", d, m_mskb);
    @(negedge clk);
    check("R10 held valid", {31'b0, rsp_valid}, 32'h1);
    check("R10 held data", rsp_rdata, d);
    rsp_ready = 1;
    @(negedge clk);
    check("R10 drained", {31'b0, rsp_valid}, 32'h0);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = 8'($urandom % 192);
      if (($urandom % 4) != 0) a[1:0] = 2'b00;
      do_chk("R6 random", bit'($urandom % 2), a, $urandom);
      check("R8 random irq", {31'b0, irq_o}, {31'b0, |(m_srca & m_mska)});
    end
    e = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule